// File: doc/BRIEF.md
# PWM Phase-Count Detector

This block works out how many regulator phases are in use, from one to eight, when the soft-start interval begins. A channel that is not used has its PWM pin tied to the supply. The other upper channels are pulled low by a weak sink. A threshold comparator on each of PWM outputs 2 to 8 reports its pin level as one bit. PWM1 is always in use. A one-cycle start pulse opens a fixed detection window. PWM1 is forced low while the window is open. On the last cycle of the window the synchronized comparator bits are decoded.

The decoded result is held until the next start pulse. It gives a phase count and a per-channel enable mask. It also gives a sink-release control for each in-use upper channel and an output-enable for each driver. Unused channels keep their sinks engaged and their drivers off. If the straps are not one contiguous group running down from PWM8, an error flag is raised. The count then falls back to the contiguous run of in-use channels starting at PWM2.

Top module: `phase_count_detect`

## Requirements
- R1: After reset: det_valid=0, det_busy=0, pwm1_low=0, strap_err=0, phase_cnt=0, ch_en=0, drv_oe=0 and sink_rel=0 (all sinks engaged).
- R2: A win_start pulse sampled while idle makes det_busy high for exactly 8 clock cycles, starting at that edge.
- R3: pwm1_low is high exactly while det_busy is high. No driver is enabled while det_busy is high.
- R4: strap_cmp bit i reports PWM(i+2), where 1 means strapped and 0 means in use. With k contiguous strapped pins from PWM8 down, phase_cnt = 8-k. No strap gives 8 phases and all seven strapped gives 1 phase.
- R5: ch_en bit j (PWM j+1) is 1 exactly for j < phase_cnt once det_valid is high.
- R6: After the window, sink_rel bit i (PWM i+2) and drv_oe bit j follow ch_en. Strapped channels keep sink_rel=0 and drv_oe=0.
- R7: A non-contiguous strap pattern (a 1 below a 0 in strap_cmp) sets strap_err=1. phase_cnt is then 1 plus the number of consecutive 0 bits starting at bit 0.
- R8: strap_cmp passes through a two-flop synchronizer and is sampled on the last window cycle. A change driven after the sixth window edge is not seen. A change before it is seen.
- R9: Results are held while idle regardless of strap_cmp changes. A win_start pulse during the window is ignored and does not extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_start | input | 1 | One-cycle pulse that opens the detection window |
| strap_cmp | input | 7 | Comparator outputs for PWM2..PWM8 (bit 0 = PWM2), 1 = above threshold |
| phase_cnt | output | 4 | Latched number of active phases |
| ch_en | output | 8 | Latched active-channel mask, bit 0 = PWM1 |
| sink_rel | output | 7 | Sink release for PWM2..PWM8, 1 = sink removed |
| drv_oe | output | 8 | Driver output enable per channel, 0 = high impedance |
| pwm1_low | output | 1 | Forces PWM1 low during detection |
| det_busy | output | 1 | Detection window open |
| det_valid | output | 1 | Latched result available |
| strap_err | output | 1 | Strap pattern not contiguous from PWM8 |

## Verification
The bench sweeps all 128 strap patterns through full detection windows. A wrong window count would move the falling edge of det_busy off the eighth cycle. A wrong decode would show as a wrong phase_cnt, mask or error flag on the first idle cycle after the window. Because of the synchronizer, a capture taken one cycle late or early shows up only for strap edges placed on the sixth window edge. Dedicated windows move the strap change to either side of that edge. Unintended state updates while idle would show within a few cycles as changed held outputs after strap_cmp is disturbed.

// File: rtl/pcd_pkg.sv
// Package: shared state type and default sizes for the phase-count detector.
package pcd_pkg;
    localparam int PCD_CHANNELS = 8;
    localparam int PCD_WINDOW   = 8;

    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;
endpackage

// File: rtl/pcd_sync.sv
// pcd_sync: multi-stage synchronizer for a bus of independent level signals.
// Assumes each bit is quasi-static; no bus coherency is provided.
module pcd_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop captures the asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // following flops let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pcd_window.sv
// pcd_window: opens a fixed-length detection window on a start pulse.
// Assumes start is a single-cycle pulse; starts during an open window are dropped.
module pcd_window
    import pcd_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIN_CYC - 1);

    win_state_t    st_q;
    logic [CW-1:0] cnt_q;

    // window state and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WIN_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                WIN_IDLE: begin
                    if (start) begin
                        st_q  <= WIN_OPEN;
                        cnt_q <= '0;
                    end
                end
                default: begin
                    if (cnt_q == LAST_IDX) begin
                        st_q  <= WIN_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    assign busy = (st_q == WIN_OPEN);
    assign last = busy && (cnt_q == LAST_IDX);
endmodule

// File: rtl/pcd_decode.sv
// pcd_decode: combinational strap decoder.
// Input bit i is the comparator of channel i+2 (1 = strapped to supply).
// Produces the contiguous-active count, channel mask and a contiguity error.
module pcd_decode #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-2:0]         straps,
    output logic [$clog2(NUM_CH+1)-1:0] count,
    output logic [NUM_CH-1:0]         mask,
    output logic                      bad_order
);
    localparam int UP = NUM_CH - 1;
    localparam int CNT_W = $clog2(NUM_CH + 1);

    // active chain: a channel is active only if all lower ones are active
    assign mask[0] = 1'b1;
    generate
        for (genvar i = 1; i < NUM_CH; i++) begin : g_chain
            assign mask[i] = mask[i-1] & ~straps[i-1];
        end
    endgenerate

    // population of the chain gives the phase count
    always_comb begin
        count = '0;
        for (int j = 0; j < NUM_CH; j++) begin
            count = count + CNT_W'(mask[j]);
        end
    end

    // a strapped pin directly below an unstrapped one breaks contiguity
    always_comb begin
        bad_order = 1'b0;
        for (int j = 0; j < UP - 1; j++) begin
            bad_order = bad_order | (straps[j] & ~straps[j+1]);
        end
    end
endmodule

// File: rtl/phase_count_detect.sv
// phase_count_detect: top of the phase-count detector.
// Synchronizes the strap comparators, runs the detection window, latches the
// decoded count/mask at the window's last cycle and drives sink and driver
// controls from the latched mask. Assumes strap_cmp is static during startup.
module phase_count_detect
    import pcd_pkg::*;
#(
    parameter int NUM_CH  = PCD_CHANNELS,
    parameter int WIN_CYC = PCD_WINDOW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          win_start,
    input  logic [NUM_CH-2:0]             strap_cmp,
    output logic [$clog2(NUM_CH+1)-1:0]   phase_cnt,
    output logic [NUM_CH-1:0]             ch_en,
    output logic [NUM_CH-2:0]             sink_rel,
    output logic [NUM_CH-1:0]             drv_oe,
    output logic                          pwm1_low,
    output logic                          det_busy,
    output logic                          det_valid,
    output logic                          strap_err
);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    logic [NUM_CH-2:0] straps_s;
    logic              win_last;
    logic [CNT_W-1:0]  dec_cnt;
    logic [NUM_CH-1:0] dec_mask;
    logic              dec_err;

    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_CH-1:0] mask_q;
    logic              err_q;
    logic              valid_q;

    pcd_sync #(.W(NUM_CH-1), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (strap_cmp),
        .d_sync  (straps_s)
    );

    pcd_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .start (win_start),
        .busy  (det_busy),
        .last  (win_last)
    );

    pcd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .straps    (straps_s),
        .count     (dec_cnt),
        .mask      (dec_mask),
        .bad_order (dec_err)
    );

    // result registers: cleared-valid on accepted start, loaded at window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (win_start && !det_busy) begin
            valid_q <= 1'b0;
        end else if (win_last) begin
            cnt_q   <= dec_cnt;
            mask_q  <= dec_mask;
            err_q   <= dec_err;
            valid_q <= 1'b1;
        end
    end

    assign phase_cnt = cnt_q;
    assign ch_en     = mask_q;
    assign strap_err = err_q;
    assign det_valid = valid_q;
    assign pwm1_low  = det_busy;
    assign drv_oe    = valid_q ? mask_q : '0;
    assign sink_rel  = valid_q ? mask_q[NUM_CH-1:1] : '0;
endmodule

// File: rtl/phase_count_detect_chk.sv
// phase_count_detect_chk: property checker bound to phase_count_detect.
module phase_count_detect_chk #(
    parameter int NUM_CH  = 8,
    parameter int WIN_CYC = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(NUM_CH+1)-1:0] phase_cnt,
    input logic [NUM_CH-1:0]           ch_en,
    input logic [NUM_CH-2:0]           sink_rel,
    input logic [NUM_CH-1:0]           drv_oe,
    input logic                        pwm1_low,
    input logic                        det_busy,
    input logic                        det_valid
);
    logic [15:0] run_q;

    // length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (det_busy) run_q <= run_q + 16'd1;
        else               run_q <= '0;
    end

    a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_busy) |-> (int'(run_q) == WIN_CYC));

    a_r3_no_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        det_busy |-> (pwm1_low && drv_oe == '0 && !det_valid));

    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> (int'(phase_cnt) >= 1 && int'(phase_cnt) <= NUM_CH));

    a_r5_mask_pop: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> ($countones(ch_en) == int'(phase_cnt) && ch_en[0]));

    a_r6_sink_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_rel & ~ch_en[NUM_CH-1:1]) == '0);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && $past(det_valid)) |-> ($stable(phase_cnt) && $stable(ch_en)));
endmodule

bind phase_count_detect phase_count_detect_chk #(.NUM_CH(NUM_CH), .WIN_CYC(WIN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_cnt (phase_cnt),
    .ch_en     (ch_en),
    .sink_rel  (sink_rel),
    .drv_oe    (drv_oe),
    .pwm1_low  (pwm1_low),
    .det_busy  (det_busy),
    .det_valid (det_valid)
);

// File: tb/phase_count_detect_bench.sv
module phase_count_detect_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_start = 1'b0;
    logic [6:0] strap_cmp = '0;
    logic [3:0] phase_cnt;
    logic [7:0] ch_en;
    logic [6:0] sink_rel;
    logic [7:0] drv_oe;
    logic       pwm1_low, det_busy, det_valid, strap_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    phase_count_detect u_phase_count_detect (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .strap_cmp(strap_cmp),
        .phase_cnt(phase_cnt), .ch_en(ch_en), .sink_rel(sink_rel), .drv_oe(drv_oe),
        .pwm1_low(pwm1_low), .det_busy(det_busy), .det_valid(det_valid),
        .strap_err(strap_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_phase(input int p);
        int n = 0;
        while (n < 7 && ((p >> n) & 1) == 0) n++;
        return n + 1;
    endfunction

    function automatic int exp_err(input int p);
        int n = exp_phase(p) - 1;
        return (p != ((127 << n) & 127)) ? 1 : 0;
    endfunction

    // pulse start at a negedge; returns after the negedge following edge E0
    task automatic pulse_start();
        @(negedge clk); win_start = 1'b1;
        @(negedge clk); win_start = 1'b0;
    endtask

    task automatic check_result(input int p, input string tag);
        int ph = exp_phase(p);
        int m = (1 << ph) - 1;
        chk({tag, " R4 phase"}, phase_cnt, ph);
        chk({tag, " R7 err"}, strap_err, exp_err(p));
        chk({tag, " R5 mask"}, ch_en, m);
        chk({tag, " R6 sink"}, sink_rel, m >> 1);
        chk({tag, " R6 oe"}, drv_oe, m);
        chk({tag, " valid"}, det_valid, 1);
    endtask

    // full window with pattern applied well before start
    task automatic run_pattern(input int p, input bit watch);
        @(negedge clk); strap_cmp = 7'(p);
        repeat (3) @(negedge clk);
        pulse_start();
        for (int k = 1; k <= 8; k++) begin
            if (watch) begin
                chk("R2 busy", det_busy, 1);
                chk("R3 pwm1_low", pwm1_low, 1);
                chk("R3 oe off", drv_oe, 0);
            end
            if (k < 8) @(negedge clk);
        end
        @(negedge clk);
        chk("R2 busy end", det_busy, 0);
        chk("R3 pwm1 release", pwm1_low, 0);
        check_result(p, "sweep");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 valid", det_valid, 0);
        chk("R1 busy", det_busy, 0);
        chk("R1 pwm1", pwm1_low, 0);
        chk("R1 err", strap_err, 0);
        chk("R1 phase", phase_cnt, 0);
        chk("R1 mask", ch_en, 0);
        chk("R1 oe", drv_oe, 0);
        chk("R1 sink", sink_rel, 0);

        // R4 R5 R6 R7 exhaustive sweep of all strap patterns
        for (int p = 0; p < 128; p++) run_pattern(p, p < 4);

        // R9 held while idle under strap disturbance
        run_pattern(7'b1110000, 1'b0);
        @(negedge clk); strap_cmp = 7'b0000101;
        repeat (6) @(negedge clk);
        check_result(7'b1110000, "R9 hold");

        // R9 start during window ignored
        @(negedge clk); strap_cmp = 7'b1000000;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        win_start = 1'b1;
        @(negedge clk); win_start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 no extend", det_busy, 0);
        check_result(7'b1000000, "R9 restart");

        // R8 change just before sixth edge is seen
        @(negedge clk); strap_cmp = 7'b0000000;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (5) @(negedge clk);
        strap_cmp = 7'b1111100;
        repeat (3) @(negedge clk);
        check_result(7'b1111100, "R8 seen");

        // R8 change after sixth edge is not seen
        @(negedge clk); strap_cmp = 7'b0000000;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (6) @(negedge clk);
        strap_cmp = 7'b1111111;
        repeat (2) @(negedge clk);
        check_result(7'b0000000, "R8 unseen");

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule